// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This block is the digital control core of a multi-rail power controller. It waits for the standby supply to clear its power-on-reset level. It then waits for the standby rail ramp to finish and lets a fixed settle delay run. At the end of that delay it captures the dual-rail strap and brings up the remaining outputs. After that it follows the two active-low sleep pins between the active, suspend-to-RAM and soft-off states.

The block drives digital enables for three loads: the dual 5V rail, the clock regulator and a select line for the source of the memory rail. Direct moves between the two sleep states are refused, and so is the disallowed pin code. Each refused request produces a one-cycle pulse. The strap is captured only while the block is active or still waiting to power up. Changes to the strap during sleep have no effect. Losing the standby supply or raising the shutdown request drops every enable at once and sends the machine back to its waiting state.

Top module: `acpi_pwr_seq`

## Requirements
- R1: Both sleep pins pass through two-flop synchronizers. The code {slp5_ni, slp3_ni} is decoded as 2'b11 = active, 2'b10 = suspend-to-RAM and 2'b00 = soft-off. A stable code is reflected on state_o within 4 clock cycles.
- R2: The code {slp5_ni, slp3_ni} = 2'b01 is disallowed and leaves the state unchanged.
- R3: A request for soft-off while in suspend-to-RAM, or for suspend-to-RAM while in soft-off, leaves the state unchanged. Only active-to-sleep and sleep-to-active moves happen.
- R4: The block leaves the wait state only after sb_ramp_done_i has been high for SETTLE_US microseconds, which is CLK_KHZ*SETTLE_US/1000 cycles, with no shutdown in between. A shutdown or POR loss restarts the full count.
- R5: The strap is captured while in the wait state, while active, and during shutdown. Its value at entry to a sleep state is held for that whole sleep state, whatever the strap pin does.
- R6: dual5_en_o is 1 when active. In suspend-to-RAM and in soft-off it equals the captured strap.
- R7: clk_reg_en_o is 1 only in the active state.
- R8: mem_src_main_o is 1 (main 3.3V switch) when active and 0 (standby pass regulator) otherwise.
- R9: When por_ok_i is 0 or shdn_i is 1, all enables (dual5_en_o, clk_reg_en_o, mem_src_main_o, rails_en_o) are 0 in the same cycle, and state_o returns to wait on the next clock edge. rails_en_o is 1 in every non-wait state.
- R10: illegal_o pulses high for exactly one cycle when a refused request (R2 or R3) begins. A refused request that persists does not produce another pulse.
- R11: state_o encodes wait = 0, active = 1, suspend-to-RAM = 2, soft-off = 3. state_o is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Standby supply above POR threshold |
| shdn_i | input | 1 | Shutdown request (soft-start held low) |
| sb_ramp_done_i | input | 1 | Standby rail ramp complete |
| slp5_ni | input | 1 | Active-low soft-off sleep pin |
| slp3_ni | input | 1 | Active-low suspend-to-RAM sleep pin |
| dual_strap_i | input | 1 | Keep dual 5V rail on in sleep when 1 |
| dual5_en_o | output | 1 | Dual 5V rail enable |
| clk_reg_en_o | output | 1 | Clock regulator enable |
| mem_src_main_o | output | 1 | Memory rail source: 1 main switch, 0 standby regulator |
| rails_en_o | output | 1 | Enable for the remaining outputs after power-up |
| state_o | output | 2 | Current power state |
| illegal_o | output | 1 | One-cycle refused-request pulse |

## Verification
The assertions assume that por_ok_i, shdn_i and sb_ramp_done_i are already synchronous to the clock. They also assume that the strap and the sleep pins are what may change at arbitrary times. The random phase keeps the sleep pins and the strap stable for six cycles per step, and it changes only one of the two in each step. This keeps every expected state change and strap capture clear of the synchronizer latency. Shutdown and POR loss come only from directed cases. In those cases the bench waits out the full settle delay before resuming random pin activity.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_RAM  = 2'd2,
    ST_OFF  = 2'd3
  } pwr_st_e;

  // {slp5_n, slp3_n}: 11 run, 10 ram, 00 off, 01 disallowed
  function automatic logic code_ok(input logic [1:0] code);
    return code != 2'b01;
  endfunction

  function automatic pwr_st_e code_to_st(input logic [1:0] code);
    case (code)
      2'b11:   return ST_RUN;
      2'b10:   return ST_RAM;
      default: return ST_OFF;
    endcase
  endfunction

  function automatic logic is_sleep(input pwr_st_e st);
    return (st == ST_RAM) || (st == ST_OFF);
  endfunction

endpackage

// File: rtl/acpi_sync2.sv
module acpi_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/acpi_settle_timer.sv
module acpi_settle_timer #(
  parameter int CLK_KHZ   = 100000,
  parameter int SETTLE_US = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic done_o
);
  localparam int TERM = CLK_KHZ * SETTLE_US / 1000;
  localparam int CW   = $clog2(TERM + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CW'(TERM);
    else if (restart_i)      cnt_q <= CW'(TERM);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign done_o = (cnt_q == '0);

  // R4
  restart_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !done_o);

  // R4
  done_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !restart_i) |=> done_o);
endmodule

// File: rtl/acpi_state_fsm.sv
module acpi_state_fsm
  import acpi_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sd_i,
  input  logic       settle_done_i,
  input  logic [1:0] code_i,
  input  logic       strap_i,
  output pwr_st_e    state_o,
  output logic       strap_o,
  output logic       illegal_o
);
  pwr_st_e state_q, state_d;
  logic    strap_q, ill_q, ill_prev_q, ill_now;
  pwr_st_e req;
  logic    req_ok;

  assign req    = code_to_st(code_i);
  assign req_ok = code_ok(code_i);

  always_comb begin
    state_d = state_q;
    if (sd_i) begin
      state_d = ST_WAIT;
    end else begin
      case (state_q)
        ST_WAIT: if (settle_done_i && req_ok) state_d = req;
        ST_RUN:  if (req_ok) state_d = req;
        ST_RAM,
        ST_OFF:  if (req_ok && req == ST_RUN) state_d = ST_RUN;
        default: state_d = ST_WAIT;
      endcase
    end
  end

  // refused request: bad code, or sleep-to-sleep jump
  always_comb begin
    ill_now = 1'b0;
    if (!sd_i) begin
      if (!req_ok) ill_now = 1'b1;
      else if (state_q == ST_RAM && req == ST_OFF) ill_now = 1'b1;
      else if (state_q == ST_OFF && req == ST_RAM) ill_now = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WAIT;
      strap_q    <= 1'b0;
      ill_q      <= 1'b0;
      ill_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ill_prev_q <= ill_now;
      ill_q      <= ill_now && !ill_prev_q;
      if (sd_i || state_q == ST_WAIT || state_q == ST_RUN) strap_q <= strap_i;
    end
  end

  assign state_o   = state_q;
  assign strap_o   = strap_q;
  assign illegal_o = ill_q;

  // R3
  no_ram_to_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAM) |=> (state_q != ST_OFF));

  // R3
  no_off_to_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF) |=> (state_q != ST_RAM));

  // R9
  shutdown_to_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_i |=> (state_q == ST_WAIT));

  // R4
  exit_after_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != ST_WAIT) && $past(state_q == ST_WAIT)) |-> $past(settle_done_i));

  // R5
  strap_hold_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_sleep(state_q) && !sd_i) |=> $stable(strap_q));

  // R10
  illegal_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);
endmodule

// File: rtl/acpi_pwr_seq.sv
module acpi_pwr_seq
  import acpi_seq_pkg::*;
#(
  parameter int CLK_KHZ   = 100000,
  parameter int SETTLE_US = 3000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_ok_i,
  input  logic       shdn_i,
  input  logic       sb_ramp_done_i,
  input  logic       slp5_ni,
  input  logic       slp3_ni,
  input  logic       dual_strap_i,
  output logic       dual5_en_o,
  output logic       clk_reg_en_o,
  output logic       mem_src_main_o,
  output logic       rails_en_o,
  output logic [1:0] state_o,
  output logic       illegal_o
);
  logic       sd;
  logic [2:0] raw_in, sync_in;
  logic       settle_done, strap_lat;
  pwr_st_e    st;

  assign sd     = !por_ok_i || shdn_i;
  assign raw_in = {slp5_ni, slp3_ni, dual_strap_i};

  acpi_sync2 #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_in)
  );

  acpi_settle_timer #(.CLK_KHZ(CLK_KHZ), .SETTLE_US(SETTLE_US)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (sd || !sb_ramp_done_i),
    .done_o    (settle_done)
  );

  acpi_state_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sd_i          (sd),
    .settle_done_i (settle_done),
    .code_i        (sync_in[2:1]),
    .strap_i       (sync_in[0]),
    .state_o       (st),
    .strap_o       (strap_lat),
    .illegal_o     (illegal_o)
  );

  assign dual5_en_o     = !sd && ((st == ST_RUN) || (is_sleep(st) && strap_lat));
  assign clk_reg_en_o   = !sd && (st == ST_RUN);
  assign mem_src_main_o = !sd && (st == ST_RUN);
  assign rails_en_o     = !sd && (st != ST_WAIT);
  assign state_o        = st;

  // R7
  clk_off_in_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'd1) |-> !clk_reg_en_o);

  // R6
  clk_implies_dual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_reg_en_o |-> (dual5_en_o && mem_src_main_o && rails_en_o));

  // R9
  shutdown_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_ok_i || shdn_i) |-> !(dual5_en_o || clk_reg_en_o || mem_src_main_o || rails_en_o));
endmodule

// File: tb/sim_acpi_pwr_seq.sv
module sim_acpi_pwr_seq;
  localparam int TERM = 100;  // CLK_KHZ=100000, SETTLE_US=1

  logic clk = 1'b0, rst_n = 1'b0;
  logic por = 1'b0, shdn = 1'b0, ramp = 1'b0;
  logic s5n = 1'b1, s3n = 1'b1, strap = 1'b1;
  logic dual5, clk_en, mem_main, rails, ill;
  logic [1:0] st;
  int n_chk = 0, n_err = 0, pulses = 0;

  always #5 clk = ~clk;

  acpi_pwr_seq #(.CLK_KHZ(100000), .SETTLE_US(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por), .shdn_i(shdn),
    .sb_ramp_done_i(ramp), .slp5_ni(s5n), .slp3_ni(s3n), .dual_strap_i(strap),
    .dual5_en_o(dual5), .clk_reg_en_o(clk_en), .mem_src_main_o(mem_main),
    .rails_en_o(rails), .state_o(st), .illegal_o(ill)
  );

  always @(negedge clk) if (ill) pulses++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // model: next state from current state and code {s5n,s3n}
  function automatic int nxt(input int cur, input logic [1:0] c);
    int req;
    if (c == 2'b01) return cur;
    req = (c == 2'b11) ? 1 : (c == 2'b10) ? 2 : 3;
    if (cur == 1) return req;
    if (req == 1) return 1;
    return cur;
  endfunction

  function automatic bit refused(input int cur, input logic [1:0] c);
    if (c == 2'b01) return 1'b1;
    if (cur == 2 && c == 2'b00) return 1'b1;
    if (cur == 3 && c == 2'b10) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int exp_dual(input int s, input bit sl);
    return (s == 1) ? 1 : (s >= 2) ? int'(sl) : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int ms, mstrap;
    bit prev_ill, now_ill;
    void'($urandom(32'd1234));
    step(3);
    rst_n = 1'b1;
    step(3);
    // R11 reset state
    chk("R11 reset state", st, 0);
    chk("R9 reset dual5", dual5, 0);
    chk("R9 reset rails", rails, 0);

    por = 1'b1;
    step(20);
    chk("R4 no ramp keeps wait", st, 0);
    ramp = 1'b1;
    step(60);
    shdn = 1'b1;
    #1 chk("R9 shutdown clk_en off", clk_en, 0);
    step(2);
    shdn = 1'b0;
    step(80);
    chk("R4 restart after shutdown", st, 0);
    step(40);
    chk("R4 R1 active after settle", st, 1);
    chk("R9 rails on", rails, 1);
    chk("R7 clk on active", clk_en, 1);
    chk("R8 mem main active", mem_main, 1);
    chk("R6 dual5 active", dual5, 1);

    // strap=1 latched, enter suspend-to-RAM
    s5n = 1'b1; s3n = 1'b0; step(5);
    chk("R1 ram decode", st, 2);
    chk("R6 dual5 ram strap1", dual5, 1);
    chk("R7 clk off ram", clk_en, 0);
    chk("R8 mem standby ram", mem_main, 0);
    strap = 1'b0; step(6);
    chk("R5 strap ignored in sleep", dual5, 1);
    pulses = 0;
    s5n = 1'b0; s3n = 1'b0; step(6);
    chk("R3 ram to off blocked", st, 2);
    chk("R10 pulse on blocked move", pulses, 1);
    s5n = 1'b1; s3n = 1'b1; step(6);
    chk("R1 back to active", st, 1);
    s5n = 1'b0; s3n = 1'b0; step(6);
    chk("R1 off decode", st, 3);
    chk("R5 R6 new strap 0 in off", dual5, 0);
    pulses = 0;
    s5n = 1'b0; s3n = 1'b1; step(8);
    chk("R2 bad code holds off", st, 3);
    chk("R10 single pulse persists", pulses, 1);
    s5n = 1'b1; s3n = 1'b1; step(6);
    s5n = 1'b0; s3n = 1'b1; step(6);
    chk("R2 bad code holds active", st, 1);
    s5n = 1'b1; s3n = 1'b1; step(6);

    por = 1'b0;
    #1 chk("R9 por loss dual5 off", dual5, 0);
    chk("R9 por loss mem off", mem_main, 0);
    step(2);
    chk("R9 por loss to wait", st, 0);
    por = 1'b1;
    strap = 1'b1;
    step(TERM + 20);
    chk("R4 recovered active", st, 1);

    ms = 1; mstrap = 1; prev_ill = 1'b0;
    for (int i = 0; i < 300; i++) begin
      logic [1:0] c;
      pulses = 0;
      if ($urandom % 4 == 0) begin
        strap = 1'($urandom);
      end else begin
        c = 2'($urandom);
        s5n = c[1]; s3n = c[0];
      end
      c = {s5n, s3n};
      now_ill = refused(ms, c);
      ms = nxt(ms, c);
      step(6);
      if (ms == 1) mstrap = int'(strap);
      chk("R1 R2 R3 random state", st, ms);
      chk("R5 R6 random dual5", dual5, exp_dual(ms, mstrap[0]));
      chk("R7 R8 random clk/mem", {clk_en, mem_main}, (ms == 1) ? 3 : 0);
      chk("R10 random pulses", pulses, (now_ill && !prev_ill) ? 1 : 0);
      prev_ill = now_ill;
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule